// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between the memory stage of a pipelined processor and a main memory that needs several cycles per access. The core presents a word address, a read or write request, store data and per-byte enables. A hit answers in the same cycle. A miss raises a stall signal that holds the pipeline until the line has been fetched. The memory side has an address, a 4-bit write enable, write data and read data that arrives a fixed number of cycles after the read address is first shown.

Each line holds one 32-bit word, and the number of lines follows from a capacity parameter. The default is 4 KB, and 8 KB is also a valid setting. Stores are write-back and write-allocate.

When the line to be replaced holds modified data, the cache first writes that data back. This write phase takes five cycles and keeps the victim address on the bus for all of them. The cache then runs the normal refill, and the access completes from the cache one cycle after the refilled word is installed. Two counters record hits and miss events.

Top module: `dcache_wb`

## Requirements
- R1: After reset every line is invalid, both counters read zero and the stall output is low while no request is present. The first access to any line therefore misses.
- R2: A load whose line is valid and whose tag matches keeps the stall output low and returns the stored word on the load-data output in the same cycle.
- R3: A store hit keeps the stall output low and leaves the memory write enable at zero. It updates the line at the end of that cycle and marks the line modified.
- R4: A miss on a clean or invalid line behaves as follows. In the detection cycle (cycle 1) the memory address equals the request address with a write enable of zero. The stall output is high in cycles 1 to 5 and the memory read data is installed in cycle 5. In cycle 6 the stall is low and the load data is valid.
- R5: A store miss first fetches the word from memory. It then merges the enabled store bytes into the fetched word before installing it, and leaves the line marked modified.
- R6: A miss on a modified line starts the eviction in cycle 1. In that cycle the memory write enable is 4'b1111 and the write data is the victim word. The address is the victim's address: the stored tag, then the index, then two zero bits. In cycles 2 to 5 the write enable is zero and the victim address is held. From cycle 6 the sequence of R4 follows for the request address, so the stall is high through cycle 10 and low in cycle 11.
- R7: A refill for a load leaves the line clean, so a later conflict miss on it performs no memory write.
- R8: The hit counter rises by one for each cycle in which a request hits. The cycle in which an access completes after its refill is not counted.
- R9: The miss counter rises by exactly one per miss event, whatever the number of stall cycles.
- R10: The address splits into a 2-bit byte offset, an index of log2(capacity/4) bits and a tag made of the remaining upper bits. Two addresses that differ only by a multiple of the capacity map to the same line and conflict. Every word inside one capacity-sized window keeps its own line.
- R11: A store changes exactly the bytes whose enable bit is set, with bit b controlling data bits 8b+7 to 8b. A store with no enable bit set changes no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | 1 | Access request from the memory stage |
| core_we | input | 1 | 1 = store, 0 = load |
| core_addr | input | ADDR_W | Byte address of the access |
| core_wdata | input | 32 | Store data |
| core_be | input | 4 | Store byte enables |
| core_rdata | output | 32 | Load data, valid when a request hits |
| core_stall | output | 1 | Holds the pipeline during a miss |
| mem_addr | output | ADDR_W | Memory address |
| mem_we | output | 4 | Memory byte write enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, fixed latency |
| hit_count | output | CNT_W | Number of hits |
| miss_count | output | CNT_W | Number of miss events |

## Verification
The checks take for granted that the core keeps its request, address, store data and enables unchanged while the stall output is high. The replay cycle after a refill is recognised by timing alone, so a changed request in that window would break both the hit count and the held victim address. The bench meets this by driving each access from one task. That task raises the request, holds every input until the stall has been low for one sampled cycle, and only then drops the request. The memory model returns data exactly four cycles after each address and applies writes on the edge where the enables are seen.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_EVICT = 2'd1,
        CS_FILL  = 2'd2
    } cstate_e;

    // Overlay the enabled byte lanes of upd onto base.
    function automatic logic [31:0] merge_bytes(
        input logic [31:0] base,
        input logic [31:0] upd,
        input logic [3:0]  be
    );
        logic [31:0] r;
        r = base;
        for (int b = 0; b < 4; b++) begin
            if (be[b]) r[8*b +: 8] = upd[8*b +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/dcache_lines.sv
module dcache_lines #(
    parameter int IDX_W = 10,
    parameter int TAG_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag,
    output logic [31:0]      rd_data,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [31:0]      wr_data,
    input  logic             wr_dirty
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_d, valid_q;
    logic [LINES-1:0] dirty_d, dirty_q;
    logic [TAG_W-1:0] tag_mem  [LINES];
    logic [31:0]      data_mem [LINES];

    // state bits: next value, then register
    always_comb begin
        valid_d = valid_q;
        dirty_d = dirty_q;
        if (wr_en) begin
            valid_d[idx] = 1'b1;
            dirty_d[idx] = wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            valid_q <= valid_d;
            dirty_q <= dirty_d;
        end
    end

    // tag and data arrays carry no reset; the valid bit guards them
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[idx]  <= wr_tag;
            data_mem[idx] <= wr_data;
        end
    end

    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];
    assign rd_tag   = tag_mem[idx];
    assign rd_data  = data_mem[idx];

endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
    import dcache_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       we,
    input  logic       hit,
    input  logic       victim_dirty,
    output logic       stall,
    output logic       store_hit,
    output logic       install,
    output logic       sel_victim,
    output logic [3:0] mem_we,
    output logic       hit_evt,
    output logic       miss_evt
);
    localparam int CW = $clog2(LAT + 1);

    typedef struct packed {
        cstate_e       st;
        logic [CW-1:0] cnt;
        logic          skip;   // next idle cycle is the replay of a refilled access
    } ctrl_s;

    ctrl_s r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.skip   = 1'b0;
        stall      = 1'b0;
        store_hit  = 1'b0;
        install    = 1'b0;
        sel_victim = 1'b0;
        mem_we     = 4'h0;
        hit_evt    = 1'b0;
        miss_evt   = 1'b0;
        unique case (r_q.st)
            CS_IDLE: begin
                if (req) begin
                    if (hit) begin
                        store_hit = we;
                        hit_evt   = !r_q.skip;
                    end else begin
                        stall    = 1'b1;
                        miss_evt = 1'b1;
                        r_d.cnt  = CW'(1);
                        if (victim_dirty) begin
                            sel_victim = 1'b1;
                            mem_we     = 4'hF;
                            r_d.st     = CS_EVICT;
                        end else begin
                            r_d.st = CS_FILL;
                        end
                    end
                end
            end
            CS_EVICT: begin
                stall      = 1'b1;
                sel_victim = 1'b1;
                if (r_q.cnt == CW'(LAT)) begin
                    r_d.st  = CS_FILL;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            CS_FILL: begin
                stall = 1'b1;
                if (r_q.cnt == CW'(LAT)) begin
                    install  = 1'b1;
                    r_d.st   = CS_IDLE;
                    r_d.cnt  = '0;
                    r_d.skip = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            default: begin
                r_d.st  = CS_IDLE;
                r_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= CS_IDLE;
            r_q.cnt  <= '0;
            r_q.skip <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/dcache_stats.sv
module dcache_stats #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_evt,
    input  logic             miss_evt,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count
);
    typedef struct packed {
        logic [CNT_W-1:0] hits;
        logic [CNT_W-1:0] misses;
    } stats_s;

    stats_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (hit_evt)  s_d.hits   = s_q.hits + CNT_W'(1);
        if (miss_evt) s_d.misses = s_q.misses + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.hits   <= '0;
            s_q.misses <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign hit_count  = s_q.hits;
    assign miss_count = s_q.misses;

endmodule

// File: rtl/dcache_wb.sv
module dcache_wb
    import dcache_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int CAP_BYTES = 4096,
    parameter int MEM_LAT   = 4,
    parameter int CNT_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_req,
    input  logic              core_we,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [31:0]       core_wdata,
    input  logic [3:0]        core_be,
    output logic [31:0]       core_rdata,
    output logic              core_stall,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_we,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    localparam int LINES = CAP_BYTES / 4;
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - 2 - IDX_W;

    logic [IDX_W-1:0] req_idx;
    logic [TAG_W-1:0] req_tag;
    logic             rd_valid, rd_dirty;
    logic [TAG_W-1:0] rd_tag;
    logic [31:0]      rd_data;
    logic             hit;
    logic             store_hit, install, sel_victim;
    logic             hit_evt, miss_evt;
    logic             wr_en;
    logic [31:0]      wr_data;

    assign req_idx = core_addr[IDX_W+1:2];
    assign req_tag = core_addr[ADDR_W-1:IDX_W+2];
    assign hit     = rd_valid && (rd_tag == req_tag);

    dcache_lines #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (req_idx),
        .rd_valid (rd_valid),
        .rd_dirty (rd_dirty),
        .rd_tag   (rd_tag),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_tag   (req_tag),
        .wr_data  (wr_data),
        .wr_dirty (core_we)
    );

    dcache_ctrl #(.LAT(MEM_LAT)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (core_req),
        .we           (core_we),
        .hit          (hit),
        .victim_dirty (rd_valid && rd_dirty),
        .stall        (core_stall),
        .store_hit    (store_hit),
        .install      (install),
        .sel_victim   (sel_victim),
        .mem_we       (mem_we),
        .hit_evt      (hit_evt),
        .miss_evt     (miss_evt)
    );

    dcache_stats #(.CNT_W(CNT_W)) u_stats (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_evt    (hit_evt),
        .miss_evt   (miss_evt),
        .hit_count  (hit_count),
        .miss_count (miss_count)
    );

    // line write: store hit merges into the stored word, refill installs
    // the memory word with a pending store merged on top
    always_comb begin
        wr_en   = store_hit || install;
        wr_data = rd_data;
        if (install) begin
            wr_data = core_we ? merge_bytes(mem_rdata, core_wdata, core_be) : mem_rdata;
        end else if (store_hit) begin
            wr_data = merge_bytes(rd_data, core_wdata, core_be);
        end
    end

    assign mem_addr   = sel_victim ? {rd_tag, req_idx, 2'b00} : core_addr;
    assign mem_wdata  = rd_data;
    assign core_rdata = rd_data;

endmodule

// File: rtl/dcache_chk.sv
module dcache_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              core_req,
    input logic [ADDR_W-1:0] core_addr,
    input logic              core_stall,
    input logic              sel_victim,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [3:0]        mem_we,
    input logic [CNT_W-1:0]  hit_count,
    input logic [CNT_W-1:0]  miss_count
);
    // input contract: the core holds its access while stalled
    assert_hold_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(core_stall) |-> (core_req && $stable(core_addr)));

    assert_we_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we != 4'h0) |=> (mem_we == 4'h0));

    assert_we_full_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we == 4'h0) || (mem_we == 4'hF));

    assert_victim_addr_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_victim && $past(sel_victim)) |-> $stable(mem_addr));

    assert_miss_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((miss_count == $past(miss_count)) ||
                  (miss_count == $past(miss_count) + CNT_W'(1))));

    assert_no_replay_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_stall) |=> $stable(hit_count));

    assert_stall_freezes_hits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        core_stall |=> $stable(hit_count));

endmodule

bind dcache_wb dcache_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_req   (core_req),
    .core_addr  (core_addr),
    .core_stall (core_stall),
    .sel_victim (sel_victim),
    .mem_addr   (mem_addr),
    .mem_we     (mem_we),
    .hit_count  (hit_count),
    .miss_count (miss_count)
);

// File: tb/sim_dcache_wb.sv
`timescale 1ns/1ps
module sim_dcache_wb;
    localparam int CAP   = 64;
    localparam int NLINE = CAP / 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        core_req, core_we;
    logic [31:0] core_addr, core_wdata;
    logic [3:0]  core_be;
    logic [31:0] core_rdata;
    logic        core_stall;
    logic [31:0] mem_addr;
    logic [3:0]  mem_we;
    logic [31:0] mem_wdata, mem_rdata;
    logic [31:0] hit_count, miss_count;

    always #2 clk = ~clk;

    dcache_wb #(.ADDR_W(32), .CAP_BYTES(CAP), .MEM_LAT(4), .CNT_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_we(core_we),
        .core_addr(core_addr), .core_wdata(core_wdata), .core_be(core_be),
        .core_rdata(core_rdata), .core_stall(core_stall), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    // main memory model: data appears four cycles after an address
    logic [31:0] bm [0:255];
    logic [31:0] rd_pipe [0:3];
    assign mem_rdata = rd_pipe[3];

    always @(posedge clk) begin
        rd_pipe[0] <= bm[mem_addr[9:2]];
        rd_pipe[1] <= rd_pipe[0];
        rd_pipe[2] <= rd_pipe[1];
        rd_pipe[3] <= rd_pipe[2];
        for (int b = 0; b < 4; b++)
            if (mem_we[b]) bm[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end

    // architectural model
    logic [31:0] refm [0:255];
    bit          vld [NLINE];
    bit          dty [NLINE];
    int          tg  [NLINE];
    int checks = 0, errors = 0;
    int exp_hit = 0, exp_miss = 0;
    bit done = 0;

    function automatic logic [31:0] mrg(logic [31:0] o, logic [31:0] n, logic [3:0] be);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
        return r;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic access(bit w, logic [31:0] a, logic [31:0] d, logic [3:0] be);
        int          idx = int'(a[5:2]);
        int          t   = int'(a[31:6]);
        bit          h   = vld[idx] && (tg[idx] == t);
        bit          dv  = vld[idx] && dty[idx] && !h;
        logic [31:0] va  = {tg[idx][25:0], a[5:2], 2'b00};
        int          n;
        @(negedge clk);
        core_req = 1'b1; core_we = w; core_addr = a; core_wdata = d; core_be = be;
        #1;
        if (h) begin
            chk("R2", "hit stall", {31'd0, core_stall}, 32'd0);
            chk("R3", "hit mem_we", {28'd0, mem_we}, 32'd0);
            if (!w) chk("R2", "hit data", core_rdata, refm[a[9:2]]);
            exp_hit++;
        end else begin
            exp_miss++;
            n = dv ? 10 : 5;
            for (int c = 1; c <= n; c++) begin
                chk("R4", "miss stall", {31'd0, core_stall}, 32'd1);
                if (dv && c <= 5) begin
                    chk("R6", "victim addr", mem_addr, va);
                    chk("R6", "evict we", {28'd0, mem_we}, (c == 1) ? 32'hF : 32'h0);
                    if (c == 1) chk("R6", "victim data", mem_wdata, refm[va[9:2]]);
                end else begin
                    chk("R4", "refill addr", mem_addr, a);
                    chk("R7", "refill we", {28'd0, mem_we}, 32'd0);
                end
                @(negedge clk); #1;
            end
            chk(dv ? "R6" : "R4", "release stall", {31'd0, core_stall}, 32'd0);
            if (!w) chk("R4", "refill data", core_rdata, refm[a[9:2]]);
        end
        if (w) refm[a[9:2]] = mrg(refm[a[9:2]], d, be);
        if (h) begin
            if (w) dty[idx] = 1;
        end else begin
            dty[idx] = w;
        end
        vld[idx] = 1; tg[idx] = t;
        @(negedge clk);
        core_req = 1'b0; core_we = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            bm[i]   = 32'h5A00_0000 ^ (i * 32'h0103_0507);
            refm[i] = 32'h5A00_0000 ^ (i * 32'h0103_0507);
        end
        for (int i = 0; i < NLINE; i++) begin vld[i] = 0; dty[i] = 0; tg[i] = 0; end
        rst_n = 1'b0; core_req = 0; core_we = 0; core_addr = 0; core_wdata = 0; core_be = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;
        chk("R1", "stall idle", {31'd0, core_stall}, 32'd0);
        chk("R1", "hits reset", hit_count, 32'd0);
        chk("R1", "misses reset", miss_count, 32'd0);

        // R1 R4: every line starts empty, clean misses
        for (int i = 0; i < NLINE; i++) access(0, i * 4, 0, 0);
        chk("R9", "miss count sweep", miss_count, exp_miss);
        chk("R8", "no replay hits", hit_count, 32'd0);
        // R2 R10: whole window resident
        for (int i = 0; i < NLINE; i++) access(0, i * 4, 0, 0);
        chk("R8", "hit count", hit_count, exp_hit);
        // R3 R11: store hits with every byte-enable pattern
        for (int i = 0; i < NLINE; i++) access(1, i * 4, 32'hC0DE_0000 | i, 4'(i));
        for (int i = 0; i < NLINE; i++) access(0, i * 4, 0, 0);
        // R6 R10: conflicting window evicts dirty lines
        for (int i = 0; i < NLINE; i++) access(0, CAP + i * 4, 0, 0);
        // R7: clean victims, stored data came back from memory
        for (int i = 0; i < NLINE; i++) access(0, i * 4, 0, 0);
        // R5: store misses allocate and merge
        for (int i = 0; i < NLINE; i++) access(1, 2 * CAP + i * 4, 32'hBEEF_0000 + i * 32'h11, 4'(15 - i));
        for (int i = 0; i < NLINE; i++) access(0, 2 * CAP + i * 4, 0, 0);
        for (int i = 0; i < NLINE; i++) access(0, i * 4, 0, 0);
        // idle cycles leave counters alone
        repeat (4) @(negedge clk);
        #1;
        chk("R8", "final hits", hit_count, exp_hit);
        chk("R9", "final misses", miss_count, exp_miss);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule